// File: doc/BRIEF.md
# Serial Link Mode Sequencer

This block decides what a word-serializing transmitter puts on its line in every word-clock cycle. After reset or a power-down it waits out a fixed clock-multiplier settling time with the line driver off. It then moves the datapath either into data mode or into synchronization mode. In synchronization mode the datapath emits alignment symbols so that a far-end receiver can recover word boundaries.

A synchronization request comes from either of two request lines. It counts only once it has been held long enough to be deliberate. Each accepted request buys a guaranteed minimum run of alignment symbols that the requester cannot cut short. A request that stays high stretches the run for as long as it remains high.

The line-driver enable combines the sequencer state with two external gates: power and output enable. Either gate can float the line at once without upsetting the internal counting.

Top module: `link_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, `mode` is LOCK (2'd0), `locked` is 0 and `drive_on` is 0.
- R2: `locked` rises after `LOCK_CYCLES` (default 2048) clock edges spent in LOCK. At the next edge the block enters DATA (2'd2) if the ORed request is low at that edge.
- R3: The two request inputs `sync_req_a` and `sync_req_b` are ORed. A run of high samples that moves from one line to the other without a gap counts as one continuous request.
- R4: A request qualifies on the `QUAL_CYCLES`-th (default 6) consecutive edge at which the ORed request is sampled high. From DATA the block is in SYNC (2'd1) right after that edge. A run one sample shorter leaves the block in DATA, and a single low sample clears the run.
- R5: Each entry into SYNC starts a burst of exactly `BURST_LEN` (default 1024) SYNC cycles. The burst is kept even if the request drops right after qualifying. With the request low, the block is in DATA after the next edge.
- R6: If the ORed request is still high when the burst completes, SYNC continues until the first edge at which the request is sampled low.
- R7: `drive_on` equals `power_en & out_en & (mode is SYNC or DATA)` as a combinational function. Toggling `out_en` does not alter the burst length or the mode sequence.
- R8: `power_en` low forces `drive_on` low at once. It puts `mode` at DOWN (2'd3) and `locked` at 0 after the next edge. When `power_en` is sampled high again the block returns to LOCK and must again count `LOCK_CYCLES` edges before `locked` rises.
- R9: If a request is qualified when lock completes, the block goes from LOCK straight into SYNC with a fresh burst. DATA is never entered while `locked` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_req_a | input | 1 | Synchronization request, line A |
| sync_req_b | input | 1 | Synchronization request, line B |
| power_en | input | 1 | Low enters power-down |
| out_en | input | 1 | Line driver output enable |
| mode | output | 2 | Datapath mode: 0 LOCK, 1 SYNC, 2 DATA, 3 DOWN |
| locked | output | 1 | Lock settling time has elapsed |
| drive_on | output | 1 | Line driver enable |

## Verification
`drive_on` is combinational, so its response to `power_en` and `out_en` is checked 1 time unit after the input changes, in the same cycle. Every mode change and the `locked` flag are registered and are due one edge after the sampled cause. Inputs are driven on the falling edge, and each check waits an exact count of rising edges before sampling at the following falling edge. The edge counts are worked out from the requirement text: the sixth high sample, the 1024th SYNC cycle, and the 2048th lock edge. Each limit is also probed one edge short, so an off-by-one shows up as a wrong mode.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  typedef enum logic [1:0] {
    M_LOCK = 2'd0,
    M_SYNC = 2'd1,
    M_DATA = 2'd2,
    M_DOWN = 2'd3
  } mode_t;

  // counter width able to hold the value n
  function automatic int ctr_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // value loaded into the burst down-counter so that the burst lasts len cycles
  function automatic int burst_reload(input int len);
    return (len < 1) ? 0 : len - 1;
  endfunction

  // modes in which the line carries symbols
  function automatic logic is_sending(input mode_t m);
    return (m == M_SYNC) || (m == M_DATA);
  endfunction

endpackage

// File: rtl/lsc_req_qual.sv
module lsc_req_qual
  import lsc_pkg::*;
#(
  parameter int QUAL_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_a,
  input  logic req_b,
  output logic req_any,
  output logic qual_now
);
  localparam int CW = ctr_w(QUAL_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  logic [CW-1:0] run_q;

  assign req_any = req_a | req_b;

  always_ff @(posedge clk) begin
    if (!rst_n)             run_q <= '0;
    else if (!req_any)      run_q <= '0;
    else if (run_q != LAST) run_q <= run_q + 1'b1;
  end

  // this sample is the QUAL_CYCLES-th (or later) consecutive high one
  assign qual_now = req_any && (run_q == LAST);
endmodule

// File: rtl/lsc_lock_timer.sv
module lsc_lock_timer
  import lsc_pkg::*;
#(
  parameter int LOCK_CYCLES = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic done
);
  localparam int CW = ctr_w(LOCK_CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(LOCK_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clr)           cnt_q <= '0;
    else if (run && !done)  cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q == LIMIT);
endmodule

// File: rtl/lsc_burst_ctr.sv
module lsc_burst_ctr
  import lsc_pkg::*;
#(
  parameter int BURST_LEN = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  output logic done
);
  localparam int CW = ctr_w(BURST_LEN);
  localparam logic [CW-1:0] RELOAD = CW'(burst_reload(BURST_LEN));

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    left_q <= '0;
    else if (start)                left_q <= RELOAD;
    else if (active && left_q != 0) left_q <= left_q - 1'b1;
  end

  assign done = (left_q == '0);
endmodule

// File: rtl/link_seq_ctrl.sv
module link_seq_ctrl
  import lsc_pkg::*;
#(
  parameter int QUAL_CYCLES = 6,
  parameter int BURST_LEN   = 1024,
  parameter int LOCK_CYCLES = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_req_a,
  input  logic       sync_req_b,
  input  logic       power_en,
  input  logic       out_en,
  output logic [1:0] mode,
  output logic       locked,
  output logic       drive_on
);
  mode_t state_q, state_d;

  // named internal events
  logic req_any;
  logic qual_now;
  logic lock_done;
  logic burst_done;
  logic burst_start;

  lsc_req_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_a   (sync_req_a),
    .req_b   (sync_req_b),
    .req_any (req_any),
    .qual_now(qual_now)
  );

  lsc_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state_q == M_LOCK),
    .clr  ((state_q == M_DOWN) || !power_en),
    .done (lock_done)
  );

  lsc_burst_ctr #(.BURST_LEN(BURST_LEN)) u_burst (
    .clk   (clk),
    .rst_n (rst_n),
    .start (burst_start),
    .active(state_q == M_SYNC),
    .done  (burst_done)
  );

  always_comb begin
    state_d = state_q;
    if (!power_en) begin
      state_d = M_DOWN;
    end else begin
      unique case (state_q)
        M_DOWN: state_d = M_LOCK;
        M_LOCK: begin
          if (lock_done && qual_now)      state_d = M_SYNC;
          else if (lock_done && !req_any) state_d = M_DATA;
        end
        M_DATA: if (qual_now) state_d = M_SYNC;
        M_SYNC: if (burst_done && !req_any) state_d = M_DATA;
        default: state_d = M_LOCK;
      endcase
    end
  end

  assign burst_start = (state_d == M_SYNC) && (state_q != M_SYNC);

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= M_LOCK;
    else        state_q <= state_d;
  end

  assign mode     = state_q;
  assign locked   = lock_done;
  assign drive_on = power_en && out_en && is_sending(state_q);
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker
  import lsc_pkg::*;
#(
  parameter int QUAL_CYCLES = 6,
  parameter int BURST_LEN   = 1024
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_req_a,
  input logic       sync_req_b,
  input logic       power_en,
  input logic       out_en,
  input logic [1:0] mode,
  input logic       locked,
  input logic       drive_on
);
  localparam int SW = ctr_w(BURST_LEN);
  localparam int HW = ctr_w(QUAL_CYCLES);
  localparam logic [SW-1:0] S_MAX = SW'(BURST_LEN);
  localparam logic [HW-1:0] H_MAX = HW'(QUAL_CYCLES);

  logic          req_or;
  logic [SW-1:0] sync_run;
  logic [HW-1:0] hi_run;

  assign req_or = sync_req_a | sync_req_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_run <= '0;
      hi_run   <= '0;
    end else begin
      if (mode != M_SYNC)       sync_run <= '0;
      else if (sync_run != S_MAX) sync_run <= sync_run + 1'b1;
      if (!req_or)              hi_run <= '0;
      else if (hi_run != H_MAX) hi_run <= hi_run + 1'b1;
    end
  end

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_LOCK || mode == M_DOWN) |-> !drive_on);           // R7
  AST_POWER_GATES_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !power_en |-> !drive_on);                                     // R8
  AST_DOWN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !power_en |=> (mode == M_DOWN && !locked));                   // R8
  AST_DATA_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DATA) |-> locked);                                 // R9
  AST_HELD_REQ_KEEPS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SYNC && req_or && power_en) |=> (mode == M_SYNC)); // R6
  AST_BURST_NOT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SYNC && power_en && sync_run < SW'(BURST_LEN - 1)) |=> (mode == M_SYNC)); // R5
  AST_NO_EARLY_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DATA && power_en && (!req_or || hi_run < HW'(QUAL_CYCLES - 1)))
      |=> (mode == M_DATA));                                      // R4
endmodule

bind link_seq_ctrl lsc_checker #(
  .QUAL_CYCLES(QUAL_CYCLES),
  .BURST_LEN  (BURST_LEN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sync_req_a(sync_req_a),
  .sync_req_b(sync_req_b),
  .power_en  (power_en),
  .out_en    (out_en),
  .mode      (mode),
  .locked    (locked),
  .drive_on  (drive_on)
);

// File: tb/link_seq_ctrl_test.sv
module link_seq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  // vector: {req_a, req_b, out_en, edges[11:0], exp_mode[1:0], exp_drive}
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b1, 12'd5,    2'd2, 1'b1},  // R4 five samples: no qualify
    {1'b0, 1'b0, 1'b1, 12'd1,    2'd2, 1'b1},  // R4 low clears run
    {1'b0, 1'b1, 1'b1, 12'd5,    2'd2, 1'b1},  // R4 five again on line B
    {1'b1, 1'b0, 1'b1, 12'd1,    2'd1, 1'b1},  // R3 hand-over to A: sixth -> SYNC
    {1'b0, 1'b0, 1'b1, 12'd1,    2'd1, 1'b1},  // R5 dropped, burst kept
    {1'b0, 1'b0, 1'b0, 12'd1,    2'd1, 1'b0},  // R7 out_en low floats line
    {1'b0, 1'b0, 1'b1, 12'd1020, 2'd1, 1'b1},  // R7 burst unaffected
    {1'b0, 1'b0, 1'b1, 12'd1,    2'd1, 1'b1},  // R5 1024th SYNC cycle
    {1'b0, 1'b0, 1'b1, 12'd1,    2'd2, 1'b1},  // R5 back to DATA
    {1'b1, 1'b0, 1'b1, 12'd6,    2'd1, 1'b1},  // R4 six samples qualify
    {1'b1, 1'b0, 1'b1, 12'd1023, 2'd1, 1'b1},  // R6 burst over, still held
    {1'b1, 1'b0, 1'b1, 12'd5,    2'd1, 1'b1},  // R6 held extends SYNC
    {1'b0, 1'b0, 1'b1, 12'd1,    2'd2, 1'b1}   // R6 release ends SYNC
  };

  logic clk = 1'b0;
  logic rst_n, sync_req_a, sync_req_b, power_en, out_en;
  logic [1:0] mode;
  logic locked, drive_on;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  link_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sync_req_a(sync_req_a), .sync_req_b(sync_req_b),
    .power_en(power_en), .out_en(out_en), .mode(mode), .locked(locked),
    .drive_on(drive_on)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sync_req_a = 1'b0; sync_req_b = 1'b0;
    power_en = 1'b1; out_en = 1'b1;
    tick(3);
    chk("R1", "mode", mode, 0);
    chk("R1", "locked", locked, 0);
    chk("R1", "drive_on", drive_on, 0);
    rst_n = 1'b1;

    tick(2047);
    chk("R2", "locked one edge early", locked, 0);
    chk("R2", "drive_on in lock", drive_on, 0);
    tick(1);
    chk("R2", "locked", locked, 1);
    chk("R2", "mode still LOCK", mode, 0);
    tick(1);
    chk("R2", "mode DATA", mode, 2);
    chk("R7", "drive_on in DATA", drive_on, 1);

    for (int i = 0; i < NVEC; i++) begin
      sync_req_a = VEC[i][17];
      sync_req_b = VEC[i][16];
      out_en     = VEC[i][15];
      tick(int'(VEC[i][14:3]));
      chk($sformatf("vec%0d", i), "mode", mode, int'(VEC[i][2:1]));
      chk($sformatf("vec%0d", i), "drive_on", drive_on, int'(VEC[i][0]));
    end

    // R8 power-down from DATA
    power_en = 1'b0;
    #1;
    chk("R8", "drive_on immediate", drive_on, 0);
    tick(1);
    chk("R8", "mode DOWN", mode, 3);
    chk("R8", "locked cleared", locked, 0);
    tick(2);
    power_en = 1'b1;
    sync_req_a = 1'b1;
    tick(1);
    chk("R8", "mode LOCK after power-up", mode, 0);
    chk("R8", "drive_on in relock", drive_on, 0);
    tick(2047);
    chk("R8", "relock one edge early", locked, 0);
    tick(1);
    chk("R8", "relocked", locked, 1);
    tick(1);
    chk("R9", "lock with qualified request -> SYNC", mode, 1);
    sync_req_a = 1'b0;
    tick(1023);
    chk("R9", "fresh burst still running", mode, 1);
    tick(1);
    chk("R9", "burst of 1024 then DATA", mode, 2);

    finish_run();
  end
endmodule